// File: doc/BRIEF.md
# Flash Read-Modify-Write Sequencer

This block sits inside a serial flash device and carries out a small data update without help from the host. One host command carries a page address and up to 128 bits of new data with a per-byte enable mask. The sequencer copies the affected 4096-bit erase block (32 pages of 128 bits) into an internal cache and merges the enabled bytes into the target page as it arrives. It then erases the block and programs all 32 pages back. When the last page is written, a single rising edge on the interrupt pin tells the host that the update is complete. The host does not poll between steps.

A page-granular variant reads, erases and reprograms only the addressed page. A staging buffer can be filled by one or more load commands that touch the array nowhere. A later commit command then writes the staged bytes into a chosen page with the page-granular sequence. The sequencer drives a behavioural array through a one-cycle request and waits for a one-cycle done pulse before it takes the next step.

Top module: `rmw_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `err`, `irq_pin` and `arr_req` are all low.
- R2: Command kind 0 (block update) issues 32 page reads over the block of `cmd_addr` (page index = address bits [4:0], block = the upper bits), then one block erase (op 1), then 32 page programs (op 3). No read comes after the erase and no program comes before it.
- R3: After an update completes, the array holds its previous contents except in the target page, where byte b (bits [8b+7:8b]) takes the new data exactly when enable bit b is 1. Every other byte and every other page is unchanged.
- R4: Command kind 1 (page update) issues exactly one read, one page erase (op 2) and one program, all at the addressed page.
- R5: Command kind 2 (buffer load) merges its enabled bytes into the staging buffer. It issues no array request and never raises `busy`.
- R6: Command kind 3 (commit) applies the staged bytes and mask to the addressed page with the page sequence of R4, then empties the staged mask, so a second commit leaves its page's data unchanged.
- R7: `irq_pin` goes from low to high in the cycle after the last program's done pulse, together with the fall of `busy`. It is low whenever `busy` is high and stays high until the next accepted command.
- R8: A command that arrives while `busy` is high is ignored and sets `err`. Once set, `err` stays high until reset.
- R9: At most one array request is outstanding at a time. `busy` stays high from the cycle after acceptance until the cycle after the final program's done pulse.
- R10: A command that arrives in the same cycle as the final done pulse is rejected as in R8, while the completion edge of R7 still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_kind | input | 2 | 0 block update, 1 page update, 2 buffer load, 3 commit |
| cmd_addr | input | ADDR_W | Page address; bits [4:0] select the page within its block |
| cmd_data | input | PAGE_W | New data for the target page |
| cmd_be | input | PAGE_W/8 | Byte enables, bit b covers data bits [8b+7:8b] |
| busy | output | 1 | A sequence is running |
| err | output | 1 | Sticky: a command was rejected |
| irq_pin | output | 1 | Completion interrupt line, rising edge on finish |
| arr_req | output | 1 | One-cycle array request |
| arr_op | output | 2 | 0 read page, 1 erase block, 2 erase page, 3 program page |
| arr_addr | output | ADDR_W | Page address of the request |
| arr_wdata | output | PAGE_W | Program data |
| arr_rdata | input | PAGE_W | Read data, valid with arr_done |
| arr_done | input | 1 | One-cycle completion pulse from the array |

## Verification
Completion of the final page program and the arrival of a new host command can land in the same cycle. In that case the sequencer must raise the interrupt and also reject the command. The bench provokes this by watching its array model until the last program has one cycle of latency left. It then presents a block command on the same half-cycle edge at which the model drives the done pulse. It then expects the interrupt edge, a set error flag, no further array traffic and an untouched array, while its cycle-level reference model checks `busy`, `irq_pin` and `err` on every clock.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the read-modify-write sequencer.
package rmw_pkg;
    typedef enum logic [1:0] {
        CMD_BLOCK  = 2'd0,
        CMD_PAGE   = 2'd1,
        CMD_LOAD   = 2'd2,
        CMD_COMMIT = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_ERASE_BK = 2'd1,
        OP_ERASE_PG = 2'd2,
        OP_PROG     = 2'd3
    } arr_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_ER_REQ,
        S_ER_WAIT,
        S_PG_REQ,
        S_PG_WAIT
    } seq_state_e;
endpackage

// File: rtl/rmw_merge.sv
`timescale 1ns/1ps
// Byte-wise merge: each output byte comes from new_i when its enable is set,
// otherwise from old_i. Assumes W is a multiple of 8. Purely combinational.
module rmw_merge #(
    parameter int W = 128
) (
    input  logic [W-1:0]   old_i,
    input  logic [W-1:0]   new_i,
    input  logic [W/8-1:0] be_i,
    output logic [W-1:0]   out_o
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // select one byte lane
        assign out_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
    end
endmodule

// File: rtl/rmw_stage.sv
`timescale 1ns/1ps
// Staging buffer filled by load commands without touching the array.
// Assumes load_i and clear_i are never high in the same cycle.
module rmw_stage #(
    parameter int W = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   data_i,
    input  logic [W/8-1:0] be_i,
    input  logic           clear_i,
    output logic [W-1:0]   data_o,
    output logic [W/8-1:0] be_o
);
    localparam int NB = W / 8;

    logic [W-1:0] merged;

    rmw_merge #(.W(W)) i_merge (
        .old_i (data_o),
        .new_i (data_i),
        .be_i  (be_i),
        .out_o (merged)
    );

    // accumulate loaded bytes; empty the mask once a commit takes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            be_o   <= '0;
        end else if (load_i) begin
            data_o <= merged;
            be_o   <= be_o | be_i;
        end else if (clear_i) begin
            be_o   <= NB'(0);
        end
    end
endmodule

// File: rtl/rmw_cache.sv
`timescale 1ns/1ps
// Block cache: DEPTH pages of W bits, one synchronous write port and one
// asynchronous read port. Contents are not reset; every slot used by a
// sequence is written before it is read.
module rmw_cache #(
    parameter int W     = 128,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] widx_i,
    input  logic [W-1:0]             wdata_i,
    input  logic [$clog2(DEPTH)-1:0] ridx_i,
    output logic [W-1:0]             rdata_o
);
    logic [W-1:0] mem [DEPTH];

    // store one page per write strobe
    always_ff @(posedge clk) begin
        if (we_i) mem[widx_i] <= wdata_i;
    end

    assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/rmw_ctrl.sv
`timescale 1ns/1ps
// Sequencer FSM: accepts a command when idle, walks read -> erase -> program
// over a whole block or a single page, waits for the array's done pulse
// after every request, flags commands that arrive while busy, and raises
// the completion interrupt. Assumes arr_done never comes in a request cycle.
module rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDXW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              arr_done,
    output logic              busy_o,
    output logic              err_o,
    output logic              irq_o,
    output logic              arr_req_o,
    output logic [1:0]        arr_op_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [IDXW-1:0]   slot_o,
    output logic              hit_o,
    output logic              cache_we_o,
    output logic              start_o,
    output logic              commit_o,
    output logic              load_o
);
    seq_state_e              state;
    logic [IDXW-1:0]         slot;
    logic [IDXW-1:0]         last;
    logic [IDXW-1:0]         tgt;
    logic [ADDR_W-IDXW-1:0]  blk;
    logic                    whole;
    logic                    accept;
    cmd_kind_e               kind;

    assign kind     = cmd_kind_e'(cmd_kind);
    assign accept   = cmd_valid && (state == S_IDLE);
    assign start_o  = accept && (kind != CMD_LOAD);
    assign commit_o = accept && (kind == CMD_COMMIT);
    assign load_o   = accept && (kind == CMD_LOAD);

    // state walk, page pointer, error and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            slot  <= '0;
            last  <= '0;
            tgt   <= '0;
            blk   <= '0;
            whole <= 1'b0;
            err_o <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            if (cmd_valid && (state != S_IDLE)) err_o <= 1'b1;
            if (accept) irq_o <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_o) begin
                        whole <= (kind == CMD_BLOCK);
                        tgt   <= cmd_addr[IDXW-1:0];
                        blk   <= cmd_addr[ADDR_W-1:IDXW];
                        slot  <= (kind == CMD_BLOCK) ? '0 : cmd_addr[IDXW-1:0];
                        last  <= (kind == CMD_BLOCK) ? '1 : cmd_addr[IDXW-1:0];
                        state <= S_RD_REQ;
                    end
                end
                S_RD_REQ:  state <= S_RD_WAIT;
                S_RD_WAIT: begin
                    if (arr_done) begin
                        if (slot == last) begin
                            state <= S_ER_REQ;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= S_RD_REQ;
                        end
                    end
                end
                S_ER_REQ:  state <= S_ER_WAIT;
                S_ER_WAIT: begin
                    if (arr_done) begin
                        slot  <= whole ? '0 : tgt;
                        state <= S_PG_REQ;
                    end
                end
                S_PG_REQ:  state <= S_PG_WAIT;
                S_PG_WAIT: begin
                    if (arr_done) begin
                        if (slot == last) begin
                            state <= S_IDLE;
                            irq_o <= 1'b1;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= S_PG_REQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // request decode for the array port
    always_comb begin
        arr_req_o = (state == S_RD_REQ) || (state == S_ER_REQ) || (state == S_PG_REQ);
        case (state)
            S_RD_REQ: arr_op_o = OP_READ;
            S_ER_REQ: arr_op_o = whole ? OP_ERASE_BK : OP_ERASE_PG;
            default:  arr_op_o = OP_PROG;
        endcase
    end

    assign busy_o     = (state != S_IDLE);
    assign arr_addr_o = {blk, slot};
    assign slot_o     = slot;
    assign hit_o      = (slot == tgt);
    assign cache_we_o = (state == S_RD_WAIT) && arr_done;
endmodule

// File: rtl/rmw_seq.sv
`timescale 1ns/1ps
// Top of the read-modify-write sequencer: ties the FSM, the block cache,
// the staging buffer and the byte merge on the read path together.
// Assumes BLOCK_PAGES is a power of two and PAGE_W a multiple of 8.
module rmw_seq #(
    parameter int PAGE_W      = 128,
    parameter int BLOCK_PAGES = 32,
    parameter int ADDR_W      = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [PAGE_W-1:0]   cmd_data,
    input  logic [PAGE_W/8-1:0] cmd_be,
    output logic                busy,
    output logic                err,
    output logic                irq_pin,
    output logic                arr_req,
    output logic [1:0]          arr_op,
    output logic [ADDR_W-1:0]   arr_addr,
    output logic [PAGE_W-1:0]   arr_wdata,
    input  logic [PAGE_W-1:0]   arr_rdata,
    input  logic                arr_done
);
    localparam int NB   = PAGE_W / 8;
    localparam int IDXW = $clog2(BLOCK_PAGES);

    logic [IDXW-1:0]   slot;
    logic              hit;
    logic              cache_we;
    logic              start;
    logic              commit;
    logic              load;
    logic [PAGE_W-1:0] stage_data;
    logic [NB-1:0]     stage_be;
    logic [PAGE_W-1:0] upd_data;
    logic [NB-1:0]     upd_be;
    logic [PAGE_W-1:0] merged;

    rmw_ctrl #(.ADDR_W(ADDR_W), .IDXW(IDXW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_addr   (cmd_addr),
        .arr_done   (arr_done),
        .busy_o     (busy),
        .err_o      (err),
        .irq_o      (irq_pin),
        .arr_req_o  (arr_req),
        .arr_op_o   (arr_op),
        .arr_addr_o (arr_addr),
        .slot_o     (slot),
        .hit_o      (hit),
        .cache_we_o (cache_we),
        .start_o    (start),
        .commit_o   (commit),
        .load_o     (load)
    );

    rmw_stage #(.W(PAGE_W)) i_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (cmd_data),
        .be_i    (cmd_be),
        .clear_i (commit),
        .data_o  (stage_data),
        .be_o    (stage_be)
    );

    // capture the update payload when a sequence starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_data <= '0;
            upd_be   <= '0;
        end else if (start) begin
            upd_data <= commit ? stage_data : cmd_data;
            upd_be   <= commit ? stage_be   : cmd_be;
        end
    end

    rmw_merge #(.W(PAGE_W)) i_merge (
        .old_i (arr_rdata),
        .new_i (upd_data),
        .be_i  (hit ? upd_be : NB'(0)),
        .out_o (merged)
    );

    rmw_cache #(.W(PAGE_W), .DEPTH(BLOCK_PAGES)) i_cache (
        .clk     (clk),
        .we_i    (cache_we),
        .widx_i  (slot),
        .wdata_i (merged),
        .ridx_i  (slot),
        .rdata_o (arr_wdata)
    );
endmodule

// File: rtl/rmw_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for rmw_seq, attached by bind. Tracks outstanding array
// requests and the number of programs issued per accepted command.
module rmw_seq_chk #(
    parameter int BLOCK_PAGES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic       busy,
    input logic       err,
    input logic       irq_pin,
    input logic       arr_req,
    input logic [1:0] arr_op,
    input logic       arr_done
);
    localparam int CW = $clog2(BLOCK_PAGES) + 1;

    logic          outst;
    logic [CW-1:0] nprog;
    logic          blk_mode;

    // one array operation in flight between request and done
    always_ff @(posedge clk) begin
        if (!rst_n)        outst <= 1'b0;
        else if (arr_req)  outst <= 1'b1;
        else if (arr_done) outst <= 1'b0;
    end

    // count program requests since the last accepted sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nprog    <= '0;
            blk_mode <= 1'b0;
        end else if (cmd_valid && !busy && (cmd_kind != 2'd2)) begin
            nprog    <= '0;
            blk_mode <= (cmd_kind == 2'd0);
        end else if (arr_req && (arr_op == 2'd3)) begin
            nprog    <= nprog + 1'b1;
        end
    end

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_req && outst));

    assert_no_req_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_req);

    assert_irq_low_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_pin);

    assert_irq_edge_with_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pin) |-> $fell(busy));

    assert_reject_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_prog_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (nprog == (blk_mode ? CW'(BLOCK_PAGES) : CW'(1))));
endmodule

bind rmw_seq rmw_seq_chk #(.BLOCK_PAGES(BLOCK_PAGES)) i_rmw_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .busy      (busy),
    .err       (err),
    .irq_pin   (irq_pin),
    .arr_req   (arr_req),
    .arr_op    (arr_op),
    .arr_done  (arr_done)
);

// File: tb/test_rmw_seq.sv
`timescale 1ns/1ps
module test_rmw_seq;
    localparam int W   = 128;
    localparam int NB  = W / 8;
    localparam int BP  = 32;
    localparam int AW  = 7;
    localparam int NPG = 1 << AW;
    localparam logic [1:0] K_BLOCK = 2'd0, K_PAGE = 2'd1, K_LOAD = 2'd2, K_COMMIT = 2'd3;
    localparam logic [1:0] O_READ = 2'd0, O_EBLK = 2'd1, O_EPG = 2'd2, O_PROG = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0]  cmd_data = '0;
    logic [NB-1:0] cmd_be = '0;
    logic          busy, err, irq_pin, arr_req;
    logic [1:0]    arr_op;
    logic [AW-1:0] arr_addr;
    logic [W-1:0]  arr_wdata;
    logic [W-1:0]  arr_rdata = '0;
    logic          arr_done = 1'b0;

    always #2.5 clk = ~clk;

    rmw_seq #(.PAGE_W(W), .BLOCK_PAGES(BP), .ADDR_W(AW)) i_rmw_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be),
        .busy(busy), .err(err), .irq_pin(irq_pin), .arr_req(arr_req),
        .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata), .arr_done(arr_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // behavioural flash array with programmable latency
    logic [W-1:0]  mem     [NPG];
    logic [W-1:0]  exp_mem [NPG];
    int            lat = 2;
    int            cd = 0;
    logic [1:0]    p_op = '0;
    logic [AW-1:0] p_addr = '0;
    logic [W-1:0]  p_wd = '0;
    logic [1:0]    done_op = '0;
    int n_rd = 0, n_eb = 0, n_ep = 0, n_pg = 0, order_bad = 0, overlap_bad = 0, phase = 0;

    always @(negedge clk) begin
        arr_done = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                case (p_op)
                    O_READ: begin
                        arr_rdata = mem[p_addr];
                        n_rd++;
                        if (phase != 0) order_bad++;
                    end
                    O_EBLK: begin
                        for (int i = 0; i < BP; i++)
                            mem[(p_addr & ~AW'(BP - 1)) | AW'(i)] = '1;
                        n_eb++;
                        if (phase != 0) order_bad++;
                        phase = 1;
                    end
                    O_EPG: begin
                        mem[p_addr] = '1;
                        n_ep++;
                        if (phase != 0) order_bad++;
                        phase = 1;
                    end
                    default: begin
                        mem[p_addr] = mem[p_addr] & p_wd;
                        n_pg++;
                        if (phase == 0) order_bad++;
                        phase = 2;
                    end
                endcase
                arr_done = 1'b1;
                done_op  = p_op;
            end
        end
        if (arr_req) begin
            if (cd != 0) overlap_bad++;
            p_op   = arr_op;
            p_addr = arr_addr;
            p_wd   = arr_wdata;
            cd     = lat;
        end
    end

    // cycle-level reference for busy, irq and err (uses bench-driven inputs only)
    logic eb = 0, ei = 0, ee = 0, was_busy = 0;
    int   left = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            eb = 0; ei = 0; ee = 0; left = 0;
        end else begin
            was_busy = eb;
            if (cmd_valid) begin
                if (was_busy) ee = 1;
                else begin
                    ei = 0;
                    if (cmd_kind != K_LOAD) begin
                        eb = 1;
                        left = (cmd_kind == K_BLOCK) ? BP : 1;
                    end
                end
            end
            if (was_busy && arr_done && done_op == O_PROG) begin
                left--;
                if (left == 0) begin eb = 0; ei = 1; end
            end
        end
    end

    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(busy === eb, "R9 busy per cycle", W'(busy), W'(eb));
            chk(irq_pin === ei, "R7 irq_pin per cycle", W'(irq_pin), W'(ei));
            chk(err === ee, "R8 err per cycle", W'(err), W'(ee));
        end
    end

    // requirement-level helpers
    function automatic logic [W-1:0] mrg(input logic [W-1:0] o, input logic [W-1:0] n, input logic [NB-1:0] be);
        logic [W-1:0] r = o;
        for (int b = 0; b < NB; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check_image(input string tag);
        int fd = -1;
        for (int i = 0; i < NPG; i++) if (fd < 0 && mem[i] !== exp_mem[i]) fd = i;
        if (fd < 0) chk(1'b1, tag, '0, '0);
        else chk(1'b0, tag, mem[fd], exp_mem[fd]);
    endtask

    task automatic clear_counts();
        n_rd = 0; n_eb = 0; n_ep = 0; n_pg = 0; order_bad = 0; overlap_bad = 0; phase = 0;
    endtask

    task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [W-1:0] d, input logic [NB-1:0] be);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d; cmd_be = be;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    logic [W-1:0]  st_d = '0;
    logic [NB-1:0] st_be = '0;

    task automatic run_cmd(input logic [1:0] k, input logic [AW-1:0] a, input logic [W-1:0] d,
                           input logic [NB-1:0] be, input bit intrude);
        clear_counts();
        case (k)
            K_BLOCK, K_PAGE: exp_mem[a] = mrg(exp_mem[a], d, be);
            K_LOAD: begin st_d = mrg(st_d, d, be); st_be = st_be | be; end
            default: begin exp_mem[a] = mrg(exp_mem[a], st_d, st_be); st_be = '0; end
        endcase
        send(k, a, d, be);
        if (intrude) begin
            repeat (5) @(negedge clk);
            send(K_PAGE, a ^ AW'(1), ~d, '1);
        end
        while (busy) @(negedge clk);
        if (k == K_BLOCK) begin
            chk(n_rd == BP, "R2 block read count", W'(n_rd), W'(BP));
            chk(n_eb == 1 && n_ep == 0, "R2 single block erase", W'(n_eb), W'(1));
            chk(n_pg == BP, "R2 block program count", W'(n_pg), W'(BP));
            chk(order_bad == 0, "R2 read-erase-program order", W'(order_bad), '0);
        end else if (k == K_LOAD) begin
            chk(n_rd + n_eb + n_ep + n_pg == 0, "R5 load leaves array idle", W'(n_rd + n_eb + n_ep + n_pg), '0);
            chk(busy == 1'b0, "R5 load never busy", W'(busy), '0);
        end else begin
            chk(n_rd == 1 && n_ep == 1 && n_eb == 0 && n_pg == 1, "R4 page sequence counts",
                W'({n_rd[7:0], n_ep[7:0], n_eb[7:0], n_pg[7:0]}), W'(32'h01010001));
            chk(order_bad == 0, "R4 page sequence order", W'(order_bad), '0);
        end
        if (k != K_LOAD) chk(irq_pin == 1'b1, "R7 irq high after finish", W'(irq_pin), W'(1));
        chk(overlap_bad == 0, "R9 one request outstanding", W'(overlap_bad), '0);
        check_image(k == K_COMMIT ? "R6 commit image" : "R3 array image");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", '0, '1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NPG; i++) begin
            mem[i] = {32'(i) * 32'h9E3779B1, 32'(i) ^ 32'hA5C3_0F1E, ~32'(i) * 32'h0101_0007, 32'(i) + 32'h1234_5678};
            exp_mem[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && err === 1'b0 && irq_pin === 1'b0 && arr_req === 1'b0, "R1 reset state",
            W'({busy, err, irq_pin, arr_req}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && err === 1'b0 && irq_pin === 1'b0 && arr_req === 1'b0, "R1 after reset",
            W'({busy, err, irq_pin, arr_req}), '0);
        cmp_en = 1;

        // R2/R3: block updates at interior, first and last page indices
        lat = 2; run_cmd(K_BLOCK, 7'h25, {4{32'hDEAD_BEEF}}, 16'hF00F, 0);
        lat = 1; run_cmd(K_BLOCK, 7'h00, {4{32'h0F0F_1234}}, 16'hFFFF, 0);
        lat = 3; run_cmd(K_BLOCK, 7'h7F, {4{32'hCAFE_F00D}}, 16'h0001, 0);
        // R3: empty mask leaves the block's data as it was
        lat = 2; run_cmd(K_BLOCK, 7'h33, '0, 16'h0000, 0);
        // R4: page-granular update
        run_cmd(K_PAGE, 7'h41, {4{32'h5555_AAAA}}, 16'h00F0, 0);
        // R5/R6: staged loads, commit, then an empty commit
        run_cmd(K_LOAD, 7'h00, {4{32'h1111_2222}}, 16'h000F, 0);
        run_cmd(K_LOAD, 7'h00, {4{32'h3333_4444}}, 16'h0F03, 0);
        run_cmd(K_COMMIT, 7'h12, '0, '0, 0);
        run_cmd(K_COMMIT, 7'h13, '0, '0, 0);

        // R10: command lands in the cycle of the final done pulse
        clear_counts();
        lat = 3;
        exp_mem[7'h58] = mrg(exp_mem[7'h58], {4{32'h7777_0000}}, 16'hFF00);
        send(K_PAGE, 7'h58, {4{32'h7777_0000}}, 16'hFF00);
        do @(posedge clk); while (!(cd == 1 && p_op == O_PROG));
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = K_BLOCK; cmd_addr = 7'h60; cmd_data = '0; cmd_be = '1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(irq_pin === 1'b1 && busy === 1'b0, "R10 completion edge survives", W'({irq_pin, busy}), W'(2'b10));
        chk(err === 1'b1, "R10 colliding command rejected", W'(err), W'(1));
        repeat (20) @(negedge clk);
        chk(n_rd == 1 && n_pg == 1, "R10 no second sequence", W'({n_rd[7:0], n_pg[7:0]}), W'(16'h0101));
        check_image("R10 array image");

        // R8: command while busy is ignored, err stays set
        run_cmd(K_BLOCK, 7'h2A, {4{32'h0BAD_C0DE}}, 16'h3C3C, 1);
        chk(err === 1'b1, "R8 err sticky", W'(err), W'(1));
        // R7: next accepted command clears the interrupt
        send(K_LOAD, 7'h00, '0, '0);
        chk(irq_pin === 1'b0, "R7 irq cleared by accept", W'(irq_pin), '0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule